// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Programmable Threshold Flags

The block is a first-in first-out buffer with separate write and read clocks. Each side keeps a binary pointer and passes it to the other side as Gray code through a two-stage synchronizer. Each side works out its occupancy from its own pointer and the synchronized pointer from the other side. The block drives four active-low status flags: empty, full, almost-empty and almost-full. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock.

The almost-empty threshold n and the almost-full threshold m are each `$clog2(DEPTH)` bits wide. Each is held as a low half of LO_W = ceil(AW/2) bits and a high half of AW-LO_W bits. The value is {high, low}. The four half registers share the data port. The low active `ofs_mode_n` input sends write strobes and read strobes to these registers instead of to the FIFO storage.

A small state machine picks the register for each access. It has four states:
- SEL_E_LO: low half of n.
- SEL_E_HI: high half of n.
- SEL_F_LO: low half of m.
- SEL_F_HI: high half of m.

It has one transition, "step", taken on each access: SEL_E_LO to SEL_E_HI to SEL_F_LO to SEL_F_HI and back to SEL_E_LO. The write domain runs one instance of this machine and the read domain runs another. Both reset to SEL_E_LO.

Top module: `pflag_fifo`

## Requirements
- R1: After reset, `empty_n`=0, `almost_empty_n`=0, `full_n`=1 and `almost_full_n`=1. Both offset selectors are in SEL_E_LO. n and m are 7, so the low halves read back 7 and the high halves read back 0 when AW=6.
- R2: When `ofs_mode_n`=0 and `wr_en_n`=0, each rising `wclk` edge stores the low bits of `din` into the selected half register. The write selector then steps SEL_E_LO, SEL_E_HI, SEL_F_LO, SEL_F_HI and wraps. A low half takes LO_W bits and a high half takes AW-LO_W bits.
- R3: When `wr_en_n`=1, a `wclk` edge changes neither the FIFO, the offsets nor the write selector. When `ofs_mode_n`=1 and `wr_en_n`=0, the edge writes `din` into the FIFO.
- R4: When `ofs_mode_n`=0 and both `rd_en1_n` and `rd_en2_n` are 0, a rising `rclk` edge loads `dout` with the half register named by the read selector, zero-extended. The read selector then steps in the same order. The FIFO read pointer does not move.
- R5: When `ofs_mode_n`=1 and both read enables are 0, a rising `rclk` edge loads `dout` with the oldest unread word and removes it. If only one read enable is low, nothing happens.
- R6: `empty_n` is 0 exactly when the FIFO holds zero words.
- R7: `full_n` is 0 exactly when the FIFO holds DEPTH words. A write while full is dropped.
- R8: A read while empty is dropped, and `dout` keeps its value.
- R9: `almost_empty_n` is 0 when the word count is n or less. It is 1 when the count is n+1 or more.
- R10: `almost_full_n` is 0 when the word count is DEPTH-m or more. It is 1 when the free space is greater than m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write clock |
| wr_en_n | input | 1 | Active-low write strobe |
| ofs_mode_n | input | 1 | Low: accesses go to the offset registers; high: accesses go to the FIFO |
| din | input | WIDTH | Write data |
| rclk | input | 1 | Read clock |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| dout | output | WIDTH | Registered read data or offset read-back |
| empty_n | output | 1 | Low when empty (read domain) |
| almost_empty_n | output | 1 | Low when count ≤ n (read domain) |
| almost_full_n | output | 1 | Low when count ≥ DEPTH-m (write domain) |
| full_n | output | 1 | Low when full (write domain) |

## Verification
The assertions check four things on every cycle:
- Neither side's occupancy ever goes past DEPTH.
- Full implies almost-full, and empty implies almost-empty.
- The write selector holds whenever there is no offset write.
- Neither an offset read-back nor a read with a single enable moves the read pointer.

Only the bench scenarios can show the rest. These are the exact flag thresholds for loaded offsets of n and m, the visiting order and wrap of the offset registers, and data ordering through the storage. They also include dropped writes when full and dropped reads when empty, each checked against a reference model after both synchronizers have settled.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } ofs_sel_t;

endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_pf_sel.sv
module fifo_pf_sel
    import fifo_pf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_sel_t sel
);
    ofs_sel_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEL_E_LO;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (step) begin
            unique case (state)
                SEL_E_LO: state_nxt = SEL_E_HI;
                SEL_E_HI: state_nxt = SEL_F_LO;
                SEL_F_LO: state_nxt = SEL_F_HI;
                SEL_F_HI: state_nxt = SEL_E_LO;
            endcase
        end
    end

    always_comb sel = state;
endmodule

// File: rtl/fifo_pf_offsets.sv
module fifo_pf_offsets
    import fifo_pf_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int AW    = 6
) (
    input  logic                 wclk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [(AW+1)/2-1:0]  wdata,
    input  ofs_sel_t             wsel,
    input  ofs_sel_t             rsel,
    output logic [AW-1:0]        n_ofs,
    output logic [AW-1:0]        m_ofs,
    output logic [WIDTH-1:0]     rb_data
);
    localparam int LO_W = (AW + 1) / 2;
    localparam int HI_W = AW - LO_W;
    localparam logic [AW-1:0] DFLT = AW'(7);

    logic [LO_W-1:0] e_lo, f_lo;
    logic [HI_W-1:0] e_hi, f_hi;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            e_lo <= DFLT[LO_W-1:0];
            e_hi <= DFLT[AW-1:LO_W];
            f_lo <= DFLT[LO_W-1:0];
            f_hi <= DFLT[AW-1:LO_W];
        end else if (wr_stb) begin
            unique case (wsel)
                SEL_E_LO: e_lo <= wdata;
                SEL_E_HI: e_hi <= wdata[HI_W-1:0];
                SEL_F_LO: f_lo <= wdata;
                SEL_F_HI: f_hi <= wdata[HI_W-1:0];
            endcase
        end
    end

    always_comb begin
        n_ofs = {e_hi, e_lo};
        m_ofs = {f_hi, f_lo};
    end

    always_comb begin
        rb_data = '0;
        unique case (rsel)
            SEL_E_LO: rb_data = WIDTH'(e_lo);
            SEL_E_HI: rb_data = WIDTH'(e_hi);
            SEL_F_LO: rb_data = WIDTH'(f_lo);
            SEL_F_HI: rb_data = WIDTH'(f_hi);
        endcase
    end
endmodule

// File: rtl/fifo_pf_wside.sv
module fifo_pf_wside #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW:0]   rgray_s,
    input  logic [AW-1:0] m_ofs,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW:0]   wcnt,
    output logic          wr_do,
    output logic          full_n,
    output logic          af_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin, wbin_nxt, rbin_s, wcnt_nxt, wfree;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    always_comb begin
        wcnt     = wbin - rbin_s;
        wr_do    = wr_req && (wcnt != PW'(DEPTH));
        wbin_nxt = wbin + PW'(wr_do);
        wcnt_nxt = wbin_nxt - rbin_s;
        wfree    = PW'(DEPTH) - wcnt_nxt;
        waddr    = wbin[AW-1:0];
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full_n <= 1'b1;
            af_n   <= 1'b1;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
            full_n <= (wcnt_nxt != PW'(DEPTH));
            af_n   <= (wfree > {1'b0, m_ofs});
        end
    end
endmodule

// File: rtl/fifo_pf_rside.sv
module fifo_pf_rside #(
    parameter int AW = 6
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] n_ofs,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [AW:0]   rcnt,
    output logic          rd_do,
    output logic          empty_n,
    output logic          ae_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin, rbin_nxt, wbin_s, rcnt_nxt;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    always_comb begin
        rcnt     = wbin_s - rbin;
        rd_do    = rd_req && (rcnt != '0);
        rbin_nxt = rbin + PW'(rd_do);
        rcnt_nxt = wbin_s - rbin_nxt;
        raddr    = rbin[AW-1:0];
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_n <= 1'b0;
            ae_n    <= 1'b0;
        end else begin
            rbin    <= rbin_nxt;
            rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
            empty_n <= (rcnt_nxt != '0);
            ae_n    <= (rcnt_nxt > {1'b0, n_ofs});
        end
    end
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9
) (
    input  logic             rst_n,
    input  logic             wclk,
    input  logic             wr_en_n,
    input  logic             ofs_mode_n,
    input  logic [WIDTH-1:0] din,
    input  logic             rclk,
    input  logic             rd_en1_n,
    input  logic             rd_en2_n,
    output logic [WIDTH-1:0] dout,
    output logic             empty_n,
    output logic             almost_empty_n,
    output logic             almost_full_n,
    output logic             full_n
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PW   = AW + 1;
    localparam int LO_W = (AW + 1) / 2;

    logic             wr_req, ofs_wr, rd_both, rd_req, ofs_rd;
    logic             wr_do, rd_do;
    logic [AW-1:0]    waddr, raddr, n_ofs, m_ofs;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s, wcnt, rcnt;
    logic [WIDTH-1:0] rb_data;
    ofs_sel_t         wsel, rsel;
    logic [WIDTH-1:0] mem [DEPTH];

    always_comb begin
        wr_req  = ofs_mode_n & ~wr_en_n;
        ofs_wr  = ~ofs_mode_n & ~wr_en_n;
        rd_both = ~rd_en1_n & ~rd_en2_n;
        rd_req  = ofs_mode_n & rd_both;
        ofs_rd  = ~ofs_mode_n & rd_both;
    end

    fifo_pf_sel u_wsel (.clk(wclk), .rst_n(rst_n), .step(ofs_wr), .sel(wsel));
    fifo_pf_sel u_rsel (.clk(rclk), .rst_n(rst_n), .step(ofs_rd), .sel(rsel));

    fifo_pf_offsets #(.WIDTH(WIDTH), .AW(AW)) u_ofs (
        .wclk(wclk), .rst_n(rst_n), .wr_stb(ofs_wr), .wdata(din[LO_W-1:0]),
        .wsel(wsel), .rsel(rsel), .n_ofs(n_ofs), .m_ofs(m_ofs), .rb_data(rb_data)
    );

    fifo_pf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
    fifo_pf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

    fifo_pf_wside #(.DEPTH(DEPTH), .AW(AW)) u_wside (
        .wclk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rgray_s(rgray_s), .m_ofs(m_ofs),
        .waddr(waddr), .wgray(wgray), .wcnt(wcnt), .wr_do(wr_do),
        .full_n(full_n), .af_n(almost_full_n)
    );

    fifo_pf_rside #(.AW(AW)) u_rside (
        .rclk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wgray_s(wgray_s), .n_ofs(n_ofs),
        .raddr(raddr), .rgray(rgray), .rcnt(rcnt), .rd_do(rd_do),
        .empty_n(empty_n), .ae_n(almost_empty_n)
    );

    always_ff @(posedge wclk) begin
        if (wr_do) mem[waddr] <= din;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)      dout <= '0;
        else if (rd_do)  dout <= mem[raddr];
        else if (ofs_rd) dout <= rb_data;
    end
endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PW    = 7
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          empty_n,
    input logic          almost_empty_n,
    input logic          full_n,
    input logic          almost_full_n,
    input logic [PW-1:0] wcnt,
    input logic [PW-1:0] rcnt,
    input logic [PW-1:0] rgray,
    input ofs_sel_t      wsel,
    input logic          ofs_wr,
    input logic          ofs_rd,
    input logic          rd_en1_n,
    input logic          rd_en2_n
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n) wcnt <= PW'(DEPTH)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n) rcnt <= PW'(DEPTH)); // R8
    AST_FULL_IS_ALMOST: assert property (@(posedge wclk) disable iff (!rst_n) !full_n |-> !almost_full_n); // R10
    AST_EMPTY_IS_ALMOST: assert property (@(posedge rclk) disable iff (!rst_n) !empty_n |-> !almost_empty_n); // R9
    AST_WSEL_HOLD: assert property (@(posedge wclk) disable iff (!rst_n) !ofs_wr |=> $stable(wsel)); // R3
    AST_OFSRD_NO_POP: assert property (@(posedge rclk) disable iff (!rst_n) ofs_rd |=> $stable(rgray)); // R4
    AST_ONE_EN_NO_POP: assert property (@(posedge rclk) disable iff (!rst_n) (rd_en1_n != rd_en2_n) |=> $stable(rgray)); // R5
endmodule

bind pflag_fifo fifo_pf_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .full_n(full_n), .almost_full_n(almost_full_n),
    .wcnt(wcnt), .rcnt(rcnt), .rgray(rgray), .wsel(wsel),
    .ofs_wr(ofs_wr), .ofs_rd(ofs_rd), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n)
);

// File: tb/pflag_fifo_bench.sv
`timescale 1ns/1ps
module pflag_fifo_bench;
    localparam int DEPTH = 64;
    localparam int WIDTH = 9;
    localparam int AW    = $clog2(DEPTH);
    localparam int LO_W  = (AW + 1) / 2;
    localparam int HI_W  = AW - LO_W;

    logic rst_n, wclk, rclk, wr_en_n, ofs_mode_n, rd_en1_n, rd_en2_n;
    logic [WIDTH-1:0] din, dout;
    logic empty_n, almost_empty_n, almost_full_n, full_n;

    pflag_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_pflag_fifo (
        .rst_n(rst_n), .wclk(wclk), .wr_en_n(wr_en_n), .ofs_mode_n(ofs_mode_n), .din(din),
        .rclk(rclk), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .dout(dout),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n), .full_n(full_n)
    );

    initial wclk = 0;
    always #4 wclk = ~wclk;
    initial rclk = 0;
    always #6.5 rclk = ~rclk;

    int checks = 0, failures = 0;
    int q[$];
    int ofs[4];
    int wsel_m = 0, rsel_m = 0;
    int last_dout = 0;

    function automatic int n_val();
        return (ofs[1] << LO_W) | ofs[0];
    endfunction
    function automatic int m_val();
        return (ofs[3] << LO_W) | ofs[2];
    endfunction
    function automatic int half_mask(int idx);
        return (idx % 2 == 0) ? ((1 << LO_W) - 1) : ((1 << HI_W) - 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge wclk);
        repeat (5) @(posedge rclk);
        repeat (2) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic check_flags(string tag);
        settle();
        chk({tag, " R6 empty_n"}, int'(empty_n), int'(q.size() != 0));
        chk({tag, " R7 full_n"}, int'(full_n), int'(q.size() != DEPTH));
        chk({tag, " R9 almost_empty_n"}, int'(almost_empty_n), int'(q.size() > n_val()));
        chk({tag, " R10 almost_full_n"}, int'(almost_full_n), int'((DEPTH - q.size()) > m_val()));
    endtask

    task automatic wr_op(logic ld_n, logic wen_n, int d);
        @(negedge wclk);
        ofs_mode_n = ld_n; wr_en_n = wen_n; din = WIDTH'(d);
        @(negedge wclk);
        ofs_mode_n = 1'b1; wr_en_n = 1'b1;
        if (!wen_n) begin
            if (ld_n) begin
                if (q.size() < DEPTH) q.push_back(d & ((1 << WIDTH) - 1));
            end else begin
                ofs[wsel_m] = d & half_mask(wsel_m);
                wsel_m = (wsel_m + 1) % 4;
            end
        end
    endtask

    task automatic rd_op(string tag, logic ld_n, logic e1, logic e2);
        @(negedge rclk);
        ofs_mode_n = ld_n; rd_en1_n = e1; rd_en2_n = e2;
        @(negedge rclk);
        ofs_mode_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        if (!e1 && !e2) begin
            if (ld_n) begin
                if (q.size() > 0) last_dout = q.pop_front();
            end else begin
                last_dout = ofs[rsel_m];
                rsel_m = (rsel_m + 1) % 4;
            end
        end
        chk({tag, " dout"}, int'(dout), last_dout);
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        ofs[0] = 7; ofs[1] = 0; ofs[2] = 7; ofs[3] = 0;
        rst_n = 0; wr_en_n = 1; ofs_mode_n = 1; rd_en1_n = 1; rd_en2_n = 1; din = '0;
        repeat (5) @(posedge wclk);
        @(negedge wclk); rst_n = 1;

        // R1: reset flags and default offsets
        @(negedge rclk);
        chk("R1 empty_n", int'(empty_n), 0);
        chk("R1 almost_empty_n", int'(almost_empty_n), 0);
        chk("R1 full_n", int'(full_n), 1);
        chk("R1 almost_full_n", int'(almost_full_n), 1);
        for (int i = 0; i < 5; i++) rd_op("R1 R4 default readback", 1'b0, 1'b0, 1'b0);

        // R2: load n=10, m=5, with ignored strobes in between (R3)
        wr_op(1'b0, 1'b0, 9'h1F2);
        wr_op(1'b0, 1'b1, 9'h0AA);
        wr_op(1'b0, 1'b0, 9'h0F9);
        wr_op(1'b1, 1'b1, 9'h055);
        wr_op(1'b0, 1'b0, 9'h005);
        wr_op(1'b0, 1'b0, 9'h1C0);
        for (int i = 0; i < 5; i++) rd_op("R2 R3 readback", 1'b0, 1'b0, 1'b0);
        chk("R2 n value", n_val(), 10);
        chk("R2 m value", m_val(), 5);
        check_flags("R3 no write");

        // fill across all thresholds
        for (int i = 0; i < DEPTH; i++) begin
            wr_op(1'b1, 1'b0, int'($urandom_range(0, 511)));
            check_flags("fill");
        end
        for (int i = 0; i < 3; i++) wr_op(1'b1, 1'b0, 9'h1FF);
        check_flags("R7 write while full");

        // R5: single-enable reads do nothing
        rd_op("R5 one enable", 1'b1, 1'b0, 1'b1);
        rd_op("R5 other enable", 1'b1, 1'b1, 1'b0);
        check_flags("R5 no pop");

        for (int i = 0; i < DEPTH; i++) begin
            rd_op("R5 drain data", 1'b1, 1'b0, 1'b0);
            check_flags("drain");
        end
        rd_op("R8 read empty", 1'b1, 1'b0, 1'b0);
        rd_op("R8 read empty again", 1'b1, 1'b0, 1'b0);
        check_flags("R8 after empty read");

        // random mix
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 99));
            if (sel < 45)      wr_op(1'b1, 1'b0, int'($urandom_range(0, 511)));
            else if (sel < 78) rd_op("R5 random read", 1'b1, 1'b0, 1'b0);
            else if (sel < 83) wr_op(1'b0, 1'b0, int'($urandom_range(0, 511)));
            else if (sel < 91) rd_op("R4 random readback", 1'b0, 1'b0, 1'b0);
            else               wr_op(1'b1, 1'b1, int'($urandom_range(0, 511)));
            check_flags("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule